// File: doc/BRIEF.md
# Sixteen-Bit Flag-Gated Arithmetic and Logic Unit

This block is the execution stage of a small microcontroller datapath. Each cycle with `op_valid` high it takes a destination operand, a source operand, a four-bit operation code and a byte/word select. It combines them and loads the outcome into a result register and a four-bit status register. The supported work is binary add and subtract, with or without the stored carry. It also covers AND, XOR, a bit-test that only sets flags, bit-clear and bit-set, and packed decimal (BCD) addition. Finally there are byte swap, byte sign extension, and three single-place right shifts: arithmetic, through carry, and logical.

Each operation has a fixed flag class, so the status register is either fully rewritten or kept intact. Bit-clear, bit-set, clear and byte swap keep every flag. The logic operations and the bit-test report zero and sign, with carry meaning "not zero". Arithmetic reports true carry and signed overflow. A one's complement is issued by software as XOR with all ones and so behaves like XOR.

In byte mode only the low eight bits of each operand take part. The upper byte of the result is zero, and N and C come from bit 7.

Top module: `alu16_flagged`

## Requirements
- R1: While `rst_n` is low, `result` is 0 and `flags` is 0. `flags` is laid out as bit 3 = V, bit 2 = N, bit 1 = Z, bit 0 = C.
- R2: A cycle with `op_valid` low changes neither `result` nor `flags`. Every change appears on the clock edge that samples `op_valid` high.
- R3: Codes 0 (add), 1 (add plus C), 2 (subtract, dst + ~src + 1) and 3 (subtract with carry, dst + ~src + C) write the sum. They set C to the carry out of the top bit, so for subtraction C = 1 means no borrow. V is set when both addends share a sign that the sum lacks.
- R4: For every operation that writes flags, N equals bit 15 of the new result (bit 7 in byte mode) and Z is 1 exactly when the new result is zero.
- R5: With `byte_mode` high, every operation other than codes 10 and 11 uses only the low byte of each operand and writes zeros to result bits 15..8.
- R6: Codes 4 (AND) and 5 (XOR) write the combination and set V = 0 and C = NOT Z.
- R7: Code 6 (bit-test) sets the flags exactly as AND would and leaves `result` unchanged.
- R8: Codes 7 (dst AND NOT src) and 8 (dst OR src) write the result and leave all four flags unchanged.
- R9: Code 15 (clear) writes 0 to `result` and leaves all four flags unchanged, including Z.
- R10: Code 9 (decimal add) adds 4-bit digits with C as the carry into the lowest digit. A digit sum above 9 is reduced by 10 modulo 16 and carries 1 into the next digit. The final digit carry goes to C and V is cleared.
- R11: Code 10 (byte swap) exchanges the two bytes of the 16-bit `dst`, ignores `byte_mode` and leaves the flags unchanged.
- R12: Code 11 (sign extend) copies `dst` bit 7 into bits 15..8 regardless of `byte_mode`. It sets N and Z from the result, V = 0 and C = NOT Z.
- R13: Codes 12, 13 and 14 shift `dst` right one place. The top bit becomes, in turn, the old sign bit, the old C, or 0. C takes the old bit 0 and V is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Clock enable: execute the presented operation |
| op_code | input | 4 | Operation code (see requirements) |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| dst | input | 16 | Destination operand, also the single operand of one-input operations |
| src | input | 16 | Source operand |
| result | output | 16 | Registered result |
| flags | output | 4 | Registered status {V, N, Z, C} |

## Verification
Every operation code is applied to all pairs drawn from sixteen operand values, in both widths and with the stored carry preset to 0 and to 1. A reference model computes the expected values arithmetically. The operand values sit on sign boundaries (7F/80, 7FFF/8000), on all-ones and zero, and on BCD digits at 9 and 99. This separates carry from signed overflow, a borrow from its absence, and the bit-7 from the bit-15 source of N and C. Held-flag operations run right after setup operations that leave distinct flag patterns, so a stray flag write shows as a mismatch. Idle cycles with changed inputs show that nothing moves without `op_valid`.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_BIT  = 4'd6,
    OP_BIC  = 4'd7,
    OP_BIS  = 4'd8,
    OP_DADD = 4'd9,
    OP_SWAP = 4'd10,
    OP_SEXT = 4'd11,
    OP_SRA  = 4'd12,
    OP_RRC  = 4'd13,
    OP_SRL  = 4'd14,
    OP_CLR  = 4'd15
  } alu_op_e;

  // How an operation treats the status register
  typedef enum logic [1:0] {
    FC_HOLD,   // keep V N Z C
    FC_ARITH,  // V and C from the binary adder
    FC_LOGIC,  // V = 0, C = not Z
    FC_CARRY   // V = 0, C from the unit
  } flag_class_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              byte_mode,
  input  logic              subtract,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              c_out,
  output logic              v_out
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] a_m, b_m, b_x;
  logic [DATA_W:0]   total;
  logic              a_top, b_top, s_top;

  always_comb begin
    b_x   = subtract ? ~b : b;
    a_m   = byte_mode ? {{HALF{1'b0}}, a[HALF-1:0]}   : a;
    b_m   = byte_mode ? {{HALF{1'b0}}, b_x[HALF-1:0]} : b_x;
    total = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin};
    sum   = byte_mode ? {{HALF{1'b0}}, total[HALF-1:0]} : total[DATA_W-1:0];
    c_out = byte_mode ? total[HALF] : total[DATA_W];
    a_top = byte_mode ? a_m[HALF-1]   : a_m[DATA_W-1];
    b_top = byte_mode ? b_m[HALF-1]   : b_m[DATA_W-1];
    s_top = byte_mode ? total[HALF-1] : total[DATA_W-1];
    v_out = (a_top == b_top) && (s_top != a_top);
  end
endmodule

// File: rtl/alu16_bcd.sv
module alu16_bcd #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              byte_mode,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              c_out
);
  localparam int HALF   = DATA_W / 2;
  localparam int DIGITS = DATA_W / 4;
  localparam int BDIG   = HALF / 4;

  logic [DIGITS:0]   chain;
  logic [DATA_W-1:0] raw_sum;

  assign chain[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] dsum;
    logic       over;
    always_comb begin
      dsum = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'd0, chain[g]};
      over = (dsum > 5'd9);
    end
    assign raw_sum[4*g +: 4] = over ? (dsum[3:0] + 4'd6) : dsum[3:0];
    assign chain[g+1]        = over;
  end

  assign sum   = byte_mode ? {{HALF{1'b0}}, raw_sum[HALF-1:0]} : raw_sum;
  assign c_out = byte_mode ? chain[BDIG] : chain[DIGITS];
endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] d,
  input  logic [DATA_W-1:0] s,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              c_out
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] mask, d_m, shifted;
  logic              fill;

  always_comb begin
    mask  = byte_mode ? {{HALF{1'b0}}, {HALF{1'b1}}} : {DATA_W{1'b1}};
    d_m   = d & mask;
    c_out = d_m[0];
    unique case (op)
      OP_SRA:  fill = byte_mode ? d_m[HALF-1] : d_m[DATA_W-1];
      OP_RRC:  fill = cin;
      default: fill = 1'b0;
    endcase
    shifted = d_m >> 1;
    if (byte_mode) shifted[HALF-1]   = fill;
    else           shifted[DATA_W-1] = fill;

    unique case (op)
      OP_AND, OP_BIT:      res = d & s & mask;
      OP_XOR:              res = (d ^ s) & mask;
      OP_BIC:              res = d & ~s & mask;
      OP_BIS:              res = (d | s) & mask;
      OP_SWAP:             res = {d[HALF-1:0], d[DATA_W-1:HALF]};
      OP_SEXT:             res = {{HALF{d[HALF-1]}}, d[HALF-1:0]};
      OP_SRA, OP_RRC, OP_SRL: res = shifted;
      default:             res = '0;
    endcase
  end
endmodule

// File: rtl/alu16_flagged.sv
module alu16_flagged
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags
);
  localparam int HALF = DATA_W / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  alu_op_e     op;
  alu_flags_t  flg_q, flg_d;
  logic [DATA_W-1:0] res_q, res_d;

  logic [DATA_W-1:0] add_sum, bcd_sum, bit_res, pick;
  logic              add_c, add_v, bcd_c, bit_c;
  logic              is_sub, add_cin, word_only, eff_byte, top_bit;
  flag_class_e       fclass;
  logic              res_en, flg_en;

  assign op = alu_op_e'(op_code);

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SUBC);
    unique case (op)
      OP_ADD:  add_cin = 1'b0;
      OP_SUB:  add_cin = 1'b1;
      default: add_cin = flg_q.c;
    endcase
    word_only = (op == OP_SWAP) || (op == OP_SEXT);
    eff_byte  = byte_mode && !word_only;
  end

  alu16_addsub #(.DATA_W(DATA_W)) addsub_i (
    .a(dst), .b(src), .byte_mode(eff_byte), .subtract(is_sub), .cin(add_cin),
    .sum(add_sum), .c_out(add_c), .v_out(add_v)
  );

  alu16_bcd #(.DATA_W(DATA_W)) bcd_i (
    .a(dst), .b(src), .byte_mode(eff_byte), .cin(flg_q.c),
    .sum(bcd_sum), .c_out(bcd_c)
  );

  alu16_bitops #(.DATA_W(DATA_W)) bitops_i (
    .op(op), .byte_mode(eff_byte), .d(dst), .s(src), .cin(flg_q.c),
    .res(bit_res), .c_out(bit_c)
  );

  // operation -> value and flag class
  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin pick = add_sum; fclass = FC_ARITH; end
      OP_AND, OP_XOR, OP_BIT, OP_SEXT:  begin pick = bit_res; fclass = FC_LOGIC; end
      OP_BIC, OP_BIS, OP_SWAP:          begin pick = bit_res; fclass = FC_HOLD;  end
      OP_DADD:                          begin pick = bcd_sum; fclass = FC_CARRY; end
      OP_SRA, OP_RRC, OP_SRL:           begin pick = bit_res; fclass = FC_CARRY; end
      default:                          begin pick = '0;      fclass = FC_HOLD;  end
    endcase
    top_bit = eff_byte ? pick[HALF-1] : pick[DATA_W-1];
  end

  // next state
  always_comb begin
    res_en = op_valid && (op != OP_BIT);
    flg_en = op_valid && (fclass != FC_HOLD);
    res_d  = res_en ? pick : res_q;
    flg_d  = flg_q;
    if (flg_en) begin
      flg_d.n = top_bit;
      flg_d.z = (pick == '0);
      unique case (fclass)
        FC_ARITH: begin flg_d.v = add_v; flg_d.c = add_c;            end
        FC_LOGIC: begin flg_d.v = 1'b0;  flg_d.c = (pick != '0);     end
        default:  begin flg_d.v = 1'b0;  flg_d.c = (op == OP_DADD) ? bcd_c : bit_c; end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign result = res_q;
  assign flags  = flg_q;
endmodule

// File: rtl/alu16_flagged_chk.sv
module alu16_flagged_chk
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic              byte_mode,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags
);
  localparam int HALF = DATA_W / 2;

  logic keeps_flags, logic_op, nz_op;
  assign keeps_flags = (op_code == OP_BIC) || (op_code == OP_BIS) ||
                       (op_code == OP_CLR) || (op_code == OP_SWAP);
  assign logic_op    = (op_code == OP_AND) || (op_code == OP_XOR);
  assign nz_op       = (op_code <= OP_XOR) || (op_code == OP_DADD);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(result) && $stable(flags)));

  a_r8_r9_r11_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && keeps_flags) |=> $stable(flags));

  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLR) |=> (result == '0));

  a_r7_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_BIT) |=> $stable(result));

  a_r6_logic_v_c: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (logic_op || op_code == OP_BIT)) |=> (!flags[3] && (flags[0] == !flags[1])));

  a_r4_n_z: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && nz_op) |=>
      ((flags[2] == ($past(byte_mode) ? result[HALF-1] : result[DATA_W-1])) &&
       (flags[1] == (result == '0))));

  a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && byte_mode && nz_op) |=> (result[DATA_W-1:HALF] == '0));
endmodule

bind alu16_flagged alu16_flagged_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .byte_mode(byte_mode), .result(result), .flags(flags)
);

// File: tb/alu16_flagged_tb.sv
module alu16_flagged_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic        byte_mode;
  logic [15:0] dst, src;
  logic [15:0] result;
  logic [3:0]  flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [15:0] exp_res;
  logic [3:0]  exp_flg;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_flagged #(.DATA_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .byte_mode(byte_mode), .dst(dst), .src(src), .result(result), .flags(flags)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0, 1, 2, 3:   return "R3";
      4, 5:         return "R6";
      6:            return "R7";
      7, 8:         return "R8";
      9:            return "R10";
      10:           return "R11";
      11:           return "R12";
      12, 13, 14:   return "R13";
      default:      return "R9";
    endcase
  endfunction

  function automatic int to_signed(input int x, input int w);
    return (x >= (1 << (w-1))) ? x - (1 << w) : x;
  endfunction

  // reference model from the requirements
  task automatic model(input int op, input bit bm, input logic [15:0] d,
                       input logic [15:0] s, output bit upd);
    int mask, w, mp, a, b, ci, sum, ss, cy, dg;
    logic [15:0] nr;
    logic v, n, z, c;
    bit wr, logic_cls;
    mask = bm ? 255 : 65535;
    w = bm ? 8 : 16;
    mp = w - 1;
    a = int'(d) & mask;
    v = 0; c = 0; wr = 1; upd = 1; logic_cls = 0; nr = '0;
    case (op)
      0, 1, 2, 3: begin
        b   = (op >= 2) ? (int'(~s) & mask) : (int'(s) & mask);
        ci  = (op == 0) ? 0 : (op == 2) ? 1 : int'(exp_flg[0]);
        sum = a + b + ci;
        nr  = 16'(sum & mask);
        c   = ((sum >> w) & 1) != 0;
        ss  = to_signed(a, w) + to_signed(b, w) + ci;
        v   = (ss > (1 << mp) - 1) || (ss < -(1 << mp));
      end
      4: begin nr = 16'(int'(d & s) & mask); logic_cls = 1; end
      5: begin nr = 16'(int'(d ^ s) & mask); logic_cls = 1; end
      6: begin nr = 16'(int'(d & s) & mask); logic_cls = 1; wr = 0; end
      7: begin nr = 16'(int'(d & ~s) & mask); upd = 0; end
      8: begin nr = 16'(int'(d | s) & mask); upd = 0; end
      9: begin
        cy = int'(exp_flg[0]);
        for (int k = 0; k < w/4; k++) begin
          dg = ((a >> (4*k)) & 15) + ((int'(s) >> (4*k)) & 15) + cy;
          if (dg > 9) begin dg = (dg - 10) % 16; cy = 1; end
          else cy = 0;
          nr[4*k +: 4] = 4'(dg);
        end
        c = cy != 0;
      end
      10: begin nr = {d[7:0], d[15:8]}; upd = 0; end
      11: begin nr = {{8{d[7]}}, d[7:0]}; logic_cls = 1; end
      12: begin nr = 16'((a >> 1) | (a & (1 << mp))); c = (a & 1) != 0; end
      13: begin nr = 16'((a >> 1) | (int'(exp_flg[0]) << mp)); c = (a & 1) != 0; end
      14: begin nr = 16'(a >> 1); c = (a & 1) != 0; end
      default: begin nr = '0; upd = 0; end
    endcase
    n = (op == 11) ? nr[15] : nr[mp];
    z = (nr == 16'd0);
    if (logic_cls) begin v = 0; c = !z; end
    if (wr)  exp_res = nr;
    if (upd) exp_flg = {v, n, z, c};
  endtask

  task automatic do_op(input int op, input bit bm, input logic [15:0] d,
                       input logic [15:0] s);
    bit upd;
    op_valid  = 1'b1;
    op_code   = 4'(op);
    byte_mode = bm;
    dst = d;
    src = s;
    model(op, bm, d, s, upd);
    @(posedge clk);
    @(negedge clk);
    check(req_of(op), "result", result, exp_res);
    check(req_of(op), "flags", {12'd0, flags}, {12'd0, exp_flg});
    if (upd) check("R4", "N,Z", {14'd0, flags[2:1]}, {14'd0, exp_flg[2:1]});
    if (bm && op != 10 && op != 11)
      check("R5", "upper byte", {8'd0, result[15:8]}, 16'd0);
  endtask

  logic [15:0] vals [16] = '{16'h0000, 16'h0001, 16'h0007, 16'h0009,
                             16'h007F, 16'h0080, 16'h00FF, 16'h0100,
                             16'h0999, 16'h5050, 16'h7FFF, 16'h8000,
                             16'h8001, 16'h9999, 16'hAAAA, 16'hFFFF};

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; byte_mode = 1'b0;
    dst = 16'h1234; src = 16'h4321;
    exp_res = '0; exp_flg = '0;
    repeat (3) @(negedge clk);
    check("R1", "reset result", result, 16'd0);
    check("R1", "reset flags", {12'd0, flags}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "after release result", result, 16'd0);

    // leave a nonzero state, then idle with different inputs
    do_op(2, 0, 16'h8000, 16'h0001);
    op_valid = 1'b0; op_code = 4'd15; dst = 16'hFFFF; src = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R2", "idle result", result, exp_res);
    check("R2", "idle flags", {12'd0, flags}, {12'd0, exp_flg});

    for (int op = 0; op < 16; op++)
      for (int bm = 0; bm < 2; bm++)
        for (int cin = 0; cin < 2; cin++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
              // preset C: add 0+0 gives C=0, subtract 0-0 gives C=1
              do_op(cin ? 2 : 0, 0, 16'h0000, 16'h0000);
              do_op(op, bm[0], vals[i], vals[j]);
            end

    op_valid = 1'b0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule